// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block brings an asynchronous DRAM out of power-on and then keeps its contents valid. After reset it holds both strobes inactive for a programmable start-up pause. It then issues a fixed number of dummy strobe cycles and raises a ready flag. From then on it spreads refresh cycles evenly over the retention period. Every cycle it issues uses CAS-before-RAS ordering, so the memory's internal row counter supplies the row and no address has to be driven.

The block shares the strobes with an access sequencer, which does the reads and writes. A grant tells the sequencer when it may start an access. When a refresh falls due, it waits until the sequencer is idle. A refresh that cannot start is recorded in a debt counter of limited depth. Once that debt is full, the grant is withdrawn until the backlog has been cleared. While `own_strobes` is high, the chip-level multiplexer takes RAS_n and CAS_n from this block and parks write enable and output enable inactive. The data bus therefore stays in high impedance during these cycles.

All strobes are active low (0 = asserted). No data flows through the block, so it has no stream interface. The grant, the request and the busy flag are plain level signals.

Top module: `rfs_sched`

## Requirements
- R1: After reset is released, `ras_n` and `cas_n` stay 1 and `seq_gnt` stays 0 until the PAUSE_CLKS-th rising clock edge. At that edge `cas_n` goes to 0 while `ras_n` stays 1.
- R2: After the pause the block issues exactly INIT_PULSES strobe cycles, each with a RAS_n pulse. `mem_ready` goes to 1 only after the last of them has ended, and it stays 1.
- R3: In every cycle the block issues, `cas_n` is 0 for at least SETUP_CLKS clocks before `ras_n` falls. `cas_n` stays 0 for as long as `ras_n` is 0, and both return to 1 on the same edge.
- R4: Each `ras_n` low pulse lasts exactly ACTIVE_CLKS clocks. Between two pulses from the block, `ras_n` is high for at least PRECH_CLKS clocks.
- R5: Once `mem_ready` is 1, a refresh falls due every RETENTION_CLKS/REFRESH_ROWS clocks. With no sequencer traffic, one refresh pulse follows each of these expiries.
- R6: A due refresh does not start while `seq_busy` is 1. While the debt is below MAX_POSTPONE, it also does not start in a cycle where `seq_req` is 1, and `seq_gnt` stays 1 during that time.
- R7: `seq_gnt` is 0 whenever `own_strobes` is 1 and whenever `mem_ready` is 0.
- R8: When MAX_POSTPONE refreshes are pending, `seq_gnt` is 0. A refresh then starts as soon as `seq_busy` is 0, even if `seq_req` is 1.
- R9: The debt never exceeds MAX_POSTPONE. Expiries that arrive while the debt is full are dropped, so a later catch-up burst has exactly MAX_POSTPONE pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_req | input | 1 | Sequencer wants to start an access |
| seq_busy | input | 1 | Sequencer is in an access or in its own precharge |
| seq_gnt | output | 1 | Sequencer may start an access this cycle |
| ras_n | output | 1 | Row strobe, active low, valid while `own_strobes` is 1 |
| cas_n | output | 1 | Column strobe, active low, valid while `own_strobes` is 1 |
| own_strobes | output | 1 | Block drives the strobes (pause, init or refresh) |
| mem_ready | output | 1 | Initialisation complete |

## Verification
Two functions can land in the same cycle: the refresh timer expiring and the sequencer asking for the strobes. The bench provokes this by holding `seq_req` high across several expiries, with the timer phase aligned to a known refresh. While the debt is below its limit, no refresh pulse may appear and the grant must stay high. When the limit is reached, exactly one refresh must displace the request. A second run holds `seq_busy` across more expiries than the debt can hold. It is judged by the catch-up burst, which must contain exactly the limit and no more.

// File: rtl/rfs_pkg.sv
`timescale 1ns/1ps
package rfs_pkg;

  typedef enum logic [2:0] {
    PH_PAUSE  = 3'd0,
    PH_IDLE   = 3'd1,
    PH_SETUP  = 3'd2,
    PH_ACTIVE = 3'd3,
    PH_PRECH  = 3'd4
  } phase_e;

  function automatic int unsigned bits_for(input int unsigned v);
    return (v <= 1) ? 1 : $clog2(v + 1);
  endfunction

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/rfs_interval_timer.sv
`timescale 1ns/1ps
module rfs_interval_timer
  import rfs_pkg::*;
#(
  parameter int unsigned INTERVAL = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int unsigned CW = bits_for(INTERVAL);
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= RELOAD;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rfs_debt_ctr.sv
`timescale 1ns/1ps
module rfs_debt_ctr
  import rfs_pkg::*;
#(
  parameter int unsigned MAX_POSTPONE = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              owe,
  input  logic                              pay,
  output logic [bits_for(MAX_POSTPONE)-1:0] level,
  output logic                              full,
  output logic                              any
);
  localparam int unsigned DW = bits_for(MAX_POSTPONE);
  localparam logic [DW-1:0] CAP = DW'(MAX_POSTPONE);

  logic [DW-1:0] lvl_q;

  assign level = lvl_q;
  assign full  = (lvl_q == CAP);
  assign any   = (lvl_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else begin
      unique case ({owe, pay})
        2'b10:   if (lvl_q != CAP) lvl_q <= lvl_q + 1'b1;
        2'b01:   if (lvl_q != '0)  lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end
endmodule

// File: rtl/rfs_strobe_seq.sv
`timescale 1ns/1ps
module rfs_strobe_seq
  import rfs_pkg::*;
#(
  parameter int unsigned PAUSE_CLKS  = 40000,
  parameter int unsigned INIT_PULSES = 8,
  parameter int unsigned SETUP_CLKS  = 2,
  parameter int unsigned ACTIVE_CLKS = 12,
  parameter int unsigned PRECH_CLKS  = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   ready,
  output logic   ras_n,
  output logic   cas_n
);
  localparam int unsigned TW = bits_for(max4(PAUSE_CLKS, SETUP_CLKS, ACTIVE_CLKS, PRECH_CLKS));
  localparam int unsigned IW = bits_for(INIT_PULSES);
  localparam logic [TW-1:0] LD_PAUSE  = TW'(PAUSE_CLKS - 1);
  localparam logic [TW-1:0] LD_SETUP  = TW'(SETUP_CLKS - 1);
  localparam logic [TW-1:0] LD_ACTIVE = TW'(ACTIVE_CLKS - 1);
  localparam logic [TW-1:0] LD_PRECH  = TW'(PRECH_CLKS - 1);
  localparam logic [IW-1:0] LD_INIT   = IW'(INIT_PULSES);

  phase_e        ph_q, ph_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [IW-1:0] left_q, left_d;
  logic          rdy_q, rdy_d;
  logic          ras_q, cas_q;
  logic          expired;

  assign expired = (tmr_q == '0);
  assign phase   = ph_q;
  assign ready   = rdy_q;
  assign ras_n   = ras_q;
  assign cas_n   = cas_q;

  always_comb begin
    ph_d   = ph_q;
    tmr_d  = tmr_q;
    left_d = left_q;
    rdy_d  = rdy_q;
    if (ph_q != PH_IDLE && !expired) tmr_d = tmr_q - 1'b1;
    unique case (ph_q)
      PH_PAUSE: begin
        if (expired) begin
          ph_d  = PH_SETUP;
          tmr_d = LD_SETUP;
        end
      end
      PH_SETUP: begin
        if (expired) begin
          ph_d  = PH_ACTIVE;
          tmr_d = LD_ACTIVE;
        end
      end
      PH_ACTIVE: begin
        if (expired) begin
          ph_d  = PH_PRECH;
          tmr_d = LD_PRECH;
          if (!rdy_q && left_q != '0) left_d = left_q - 1'b1;
        end
      end
      PH_PRECH: begin
        if (expired) begin
          if (!rdy_q && left_q != '0) begin
            ph_d  = PH_SETUP;
            tmr_d = LD_SETUP;
          end else begin
            ph_d  = PH_IDLE;
            rdy_d = 1'b1;
          end
        end
      end
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_SETUP;
          tmr_d = LD_SETUP;
        end
      end
      default: ph_d = PH_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_PAUSE;
      tmr_q  <= LD_PAUSE;
      left_q <= LD_INIT;
      rdy_q  <= 1'b0;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      tmr_q  <= tmr_d;
      left_q <= left_d;
      rdy_q  <= rdy_d;
      ras_q  <= (ph_d != PH_ACTIVE);
      cas_q  <= !(ph_d == PH_SETUP || ph_d == PH_ACTIVE);
    end
  end
endmodule

// File: rtl/rfs_sched.sv
`timescale 1ns/1ps
module rfs_sched
  import rfs_pkg::*;
#(
  parameter int unsigned PAUSE_CLKS     = 40000,
  parameter int unsigned INIT_PULSES    = 8,
  parameter int unsigned RETENTION_CLKS = 6400000,
  parameter int unsigned REFRESH_ROWS   = 2048,
  parameter int unsigned SETUP_CLKS     = 2,
  parameter int unsigned ACTIVE_CLKS    = 12,
  parameter int unsigned PRECH_CLKS     = 8,
  parameter int unsigned MAX_POSTPONE   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_req,
  input  logic seq_busy,
  output logic seq_gnt,
  output logic ras_n,
  output logic cas_n,
  output logic own_strobes,
  output logic mem_ready
);
  localparam int unsigned INTERVAL = RETENTION_CLKS / REFRESH_ROWS;
  localparam int unsigned DEBT_W   = bits_for(MAX_POSTPONE);

  phase_e              phase;
  logic                idle, expire, take, base_gnt;
  logic [DEBT_W-1:0]   debt_level;
  logic                debt_full, debt_any;

  rfs_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (mem_ready),
    .expire (expire)
  );

  rfs_debt_ctr #(.MAX_POSTPONE(MAX_POSTPONE)) u_debt (
    .clk   (clk),
    .rst_n (rst_n),
    .owe   (expire),
    .pay   (take),
    .level (debt_level),
    .full  (debt_full),
    .any   (debt_any)
  );

  rfs_strobe_seq #(
    .PAUSE_CLKS  (PAUSE_CLKS),
    .INIT_PULSES (INIT_PULSES),
    .SETUP_CLKS  (SETUP_CLKS),
    .ACTIVE_CLKS (ACTIVE_CLKS),
    .PRECH_CLKS  (PRECH_CLKS)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (take),
    .phase (phase),
    .ready (mem_ready),
    .ras_n (ras_n),
    .cas_n (cas_n)
  );

  // Arbitration: the sequencer wins while the debt has room; a full debt wins.
  assign idle        = (phase == PH_IDLE);
  assign base_gnt    = idle && mem_ready && !debt_full;
  assign take        = idle && mem_ready && debt_any && !seq_busy && !(seq_req && base_gnt);
  assign seq_gnt     = base_gnt && !take;
  assign own_strobes = !idle;
endmodule

// File: rtl/rfs_sched_chk.sv
`timescale 1ns/1ps
module rfs_sched_chk
  import rfs_pkg::*;
#(
  parameter int unsigned PAUSE_CLKS   = 40000,
  parameter int unsigned INIT_PULSES  = 8,
  parameter int unsigned ACTIVE_CLKS  = 12,
  parameter int unsigned PRECH_CLKS   = 8,
  parameter int unsigned MAX_POSTPONE = 8
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              seq_busy,
  input logic                              seq_gnt,
  input logic                              ras_n,
  input logic                              cas_n,
  input logic                              own_strobes,
  input logic                              mem_ready,
  input logic [bits_for(MAX_POSTPONE)-1:0] debt_level
);
  localparam int unsigned DW = bits_for(MAX_POSTPONE);

  int unsigned since_rst, lo_run, hi_run, falls;
  logic        ras_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 0;
      lo_run    <= 0;
      hi_run    <= 0;
      falls     <= 0;
      ras_q     <= 1'b1;
    end else begin
      if (since_rst < PAUSE_CLKS) since_rst <= since_rst + 1;
      lo_run <= ras_n ? 0 : lo_run + 1;
      if (!ras_n)                   hi_run <= 0;
      else if (hi_run < PRECH_CLKS) hi_run <= hi_run + 1;
      if (ras_q && !ras_n && falls <= INIT_PULSES) falls <= falls + 1;
      ras_q <= ras_n;
    end
  end

  assert_pause_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < PAUSE_CLKS) |-> (ras_n && cas_n && !seq_gnt));

  assert_init_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> (falls == INIT_PULSES));

  assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mem_ready) |-> mem_ready);

  assert_cas_under_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> !cas_n);

  assert_cas_leads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $past(!cas_n));

  assert_joint_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> ras_n);

  assert_ras_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_run == ACTIVE_CLKS));

  assert_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_run >= PRECH_CLKS));

  assert_wait_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && mem_ready) |-> !$past(seq_busy));

  assert_grant_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_strobes || !mem_ready) |-> !seq_gnt);

  assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (debt_level == DW'(MAX_POSTPONE)) |-> !seq_gnt);

  assert_debt_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (debt_level <= DW'(MAX_POSTPONE)));
endmodule

bind rfs_sched rfs_sched_chk #(
  .PAUSE_CLKS   (PAUSE_CLKS),
  .INIT_PULSES  (INIT_PULSES),
  .ACTIVE_CLKS  (ACTIVE_CLKS),
  .PRECH_CLKS   (PRECH_CLKS),
  .MAX_POSTPONE (MAX_POSTPONE)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .seq_busy    (seq_busy),
  .seq_gnt     (seq_gnt),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .own_strobes (own_strobes),
  .mem_ready   (mem_ready),
  .debt_level  (debt_level)
);

// File: tb/rfs_sched_test.sv
`timescale 1ns/1ps
module rfs_sched_test;
  localparam int unsigned PAUSE  = 100;
  localparam int unsigned INIT   = 8;
  localparam int unsigned RET    = 1600;
  localparam int unsigned ROWS   = 16;
  localparam int unsigned SETUP  = 2;
  localparam int unsigned ACTIVE = 4;
  localparam int unsigned PRECH  = 3;
  localparam int unsigned MAXP   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_req = 1'b0;
  logic seq_busy = 1'b0;
  logic seq_gnt, ras_n, cas_n, own_strobes, mem_ready;

  always #2.5 clk = ~clk;

  rfs_sched #(
    .PAUSE_CLKS(PAUSE), .INIT_PULSES(INIT), .RETENTION_CLKS(RET), .REFRESH_ROWS(ROWS),
    .SETUP_CLKS(SETUP), .ACTIVE_CLKS(ACTIVE), .PRECH_CLKS(PRECH), .MAX_POSTPONE(MAXP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .seq_req(seq_req), .seq_busy(seq_busy), .seq_gnt(seq_gnt),
    .ras_n(ras_n), .cas_n(cas_n), .own_strobes(own_strobes), .mem_ready(mem_ready)
  );

  typedef struct { int unsigned width; string req; } exp_t;
  exp_t sb_q[$];
  exp_t e;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_pulses(input int n, input string req);
    for (int i = 0; i < n; i++) sb_q.push_back('{ACTIVE, req});
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drained(input string req, input string what);
    check(sb_q.size() == 0, req, what, sb_q.size(), 0);
  endtask

  // Monitor: pops one expected pulse per RAS_n pulse and checks its shape.
  bit prev_ras = 1'b1;
  bit seen = 1'b0;
  int unsigned cas_lo = 0, ras_lo = 0, ras_hi = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !ras_n) begin
        check(!cas_n && cas_lo >= SETUP, "R3", "CAS lead before RAS fall", cas_lo, SETUP);
        if (seen) check(ras_hi >= PRECH, "R4", "precharge before RAS fall", ras_hi, PRECH);
      end
      if (!ras_n && cas_n) check(1'b0, "R3", "CAS high while RAS low", 1, 0);
      if (!prev_ras && ras_n) begin
        check(cas_n == 1'b1, "R3", "CAS released with RAS", cas_n, 1);
        if (sb_q.size() == 0) begin
          check(1'b0, "R6", "unexpected RAS pulse", pulses + 1, pulses);
        end else begin
          e = sb_q.pop_front();
          check(ras_lo == e.width, e.req, "RAS low width", ras_lo, e.width);
        end
        pulses++;
        seen = 1'b1;
      end
      if (own_strobes && seq_gnt) check(1'b0, "R7", "grant while block owns strobes", 1, 0);
      cas_lo = cas_n ? 0 : cas_lo + 1;
      ras_lo = ras_n ? 0 : ras_lo + 1;
      ras_hi = ras_n ? ras_hi + 1 : 0;
      prev_ras = ras_n;
    end
  end

  initial begin
    int bad;
    wait_clks(4);
    check(ras_n && cas_n, "R1", "strobes idle in reset", {ras_n, cas_n}, 3);
    check(!mem_ready && !seq_gnt, "R7", "no ready or grant in reset", {mem_ready, seq_gnt}, 0);
    rst_n = 1'b1;
    expect_pulses(INIT, "R2");

    // R1: pause with strobes high, then CAS first.
    bad = 0;
    for (int i = 0; i < int'(PAUSE) - 1; i++) begin
      @(negedge clk);
      if (!ras_n || !cas_n || seq_gnt) bad++;
    end
    check(bad == 0, "R1", "strobes quiet during pause", bad, 0);
    @(negedge clk);
    check(!cas_n && ras_n, "R1", "CAS low first at end of pause", {ras_n, cas_n}, 2);

    // R2: ready only after all init pulses.
    while (!mem_ready) @(negedge clk);
    check(pulses == INIT, "R2", "init pulses before ready", pulses, INIT);
    drained("R2", "init scoreboard");
    check(seq_gnt == 1'b1, "R7", "grant once ready and idle", seq_gnt, 1);

    // R5: steady rate with no traffic.
    expect_pulses(10, "R5");
    wait_clks(1050);
    drained("R5", "ten refreshes in ten intervals");
    check(mem_ready == 1'b1, "R2", "ready stays high", mem_ready, 1);

    // Align the timer phase on a refresh.
    expect_pulses(1, "R5");
    @(posedge ras_n);
    wait_clks(5);

    // R6: request held across three expiries defers refresh.
    seq_req = 1'b1;
    wait_clks(300);
    check(seq_gnt == 1'b1, "R6", "grant held while debt below limit", seq_gnt, 1);
    drained("R6", "no refresh under request");
    seq_req = 1'b0;
    expect_pulses(3, "R6");
    wait_clks(40);
    drained("R6", "deferred refreshes after request drops");

    expect_pulses(1, "R5");
    @(posedge ras_n);
    wait_clks(5);

    // R8: request held until the debt fills; one refresh displaces it.
    seq_req = 1'b1;
    expect_pulses(1, "R8");
    wait_clks(420);
    drained("R8", "forced refresh at debt limit");
    check(seq_gnt == 1'b1, "R8", "grant back below limit", seq_gnt, 1);
    seq_req = 1'b0;
    expect_pulses(3, "R8");
    wait_clks(35);
    drained("R8", "remaining debt repaid");

    expect_pulses(1, "R5");
    @(posedge ras_n);
    wait_clks(5);

    // R9: busy across six expiries; only the limit is repaid.
    seq_busy = 1'b1;
    wait_clks(600);
    check(seq_gnt == 1'b0, "R8", "grant withdrawn at debt limit", seq_gnt, 0);
    drained("R6", "no refresh while sequencer busy");
    wait_clks(20);
    seq_busy = 1'b0;
    expect_pulses(MAXP, "R9");
    wait_clks(45);
    drained("R9", "catch-up burst length");
    check(seq_gnt == 1'b1, "R9", "grant restored after catch-up", seq_gnt, 1);
    expect_pulses(1, "R9");
    wait_clks(60);
    drained("R9", "extra expiries dropped");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule